// File: doc/BRIEF.md
# Software-Generated Interrupt Router

A core writes a 64-bit request word to one of three interrupt-generation ports. The router decides which cores of the cluster receive the interrupt and with which group and security attribute. It then produces a one-cycle delivery strobe for each targeted core, together with the interrupt number, the resolved group and the non-secure attribute. Each core carries a fixed 32-bit affinity identifier, `{level3, level2, level1, level0}`, which is set through the `CORE_AFF` parameter.

The request word can be decoded in two ways, chosen by bit 40:

- **Broadcast:** the interrupt goes to every core except the one that wrote it.
- **Targeted:** the three upper affinity bytes name one cluster, and a 16-bit list selects cores within that cluster by their level-0 number.

The resolved group depends on three things: the port written, the requester's security state, and a distributor-level security-disable flag. Pending state, priority and the receiving side's access checks belong to the blocks that consume the strobes.

Top module: `sgi_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dlv_vec`, `dlv_id`, `dlv_grp` and `dlv_ns` are all zero.
- R2: `dlv_id` equals bits [27:24] of the accepted request word.
- R3: With bit 40 clear, core c is strobed exactly when three conditions hold: its affinity bits [31:8] equal `{req_data[55:48], req_data[39:32], req_data[23:16]}`; its level-0 byte is 15 or less; and `req_data[level0]` is set.
- R4: With bit 40 clear, a core whose level-0 byte exceeds 15 is never strobed.
- R5: With bit 40 set, every core except `req_core` is strobed, whatever bits [15:0] and the affinity fields hold.
- R6: `req_port` = 0 (group-0 port) gives `dlv_grp` = 0. The group encoding is: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R7: `req_port` = 1 (current-state group-1 port) gives `dlv_grp` = 2 when `req_ns` is 1, and 1 otherwise.
- R8: `req_port` = 2 (other-state group-1 port) gives `dlv_grp` = 1 when `req_ns` is 1, and 2 otherwise.
- R9: When `sec_disable` is 1, a resolved secure group 1 is delivered as group 0.
- R10: `dlv_ns` equals `req_ns` of the accepted request, whichever port was written.
- R11: The strobes appear in the cycle after `req_valid`, last exactly one cycle, and `dlv_id`/`dlv_grp`/`dlv_ns` are valid in that cycle.
- R12: `req_port` = 3 produces no strobe. A request that matches no core yields an all-zero `dlv_vec` without error. Bits [63:56], [47:41] and [31:28] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request write strobe |
| req_data | input | 64 | Request word |
| req_port | input | 2 | Port written: 0 group 0, 1 current-state group 1, 2 other-state group 1, 3 none |
| req_core | input | $clog2(NCORES) | Index of the requesting core |
| req_ns | input | 1 | Requester is non-secure |
| sec_disable | input | 1 | Distributor security-disable flag |
| dlv_vec | output | NCORES | One-cycle delivery strobe per core |
| dlv_id | output | 4 | Interrupt number |
| dlv_grp | output | 2 | Resolved group |
| dlv_ns | output | 1 | Non-secure attribute |

## Verification
Targeted requests are tried with several affinity patterns:

- A list covering the whole of cluster 0 shows whether the level-0 bit indexing is correct.
- A cluster that differs only in level 3 or level 2 exposes a field packed in the wrong place.
- A full 0xFFFF list on a cluster that holds a core with a level-0 byte above 15 separates the bound check from plain bit indexing.

Broadcast requests carry a garbage list and affinity, from different requesters, which shows that self-exclusion uses the requester index and that the other fields are ignored. Every combination of port, security state and disable flag is driven directly to pin down the group table. Seeded random words, biased toward existing clusters, then mix all of these with noise in the unused bits.

// File: rtl/sgi_router.sv
module sgi_router #(
  parameter int NCORES = 8,
  parameter logic [NCORES*32-1:0] CORE_AFF = {
    32'h0000_0114, 32'h0102_0100, 32'h0000_0105, 32'h0000_0100,
    32'h0000_000F, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000
  },
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_data,
  input  logic [1:0]        req_port,
  input  logic [CW-1:0]     req_core,
  input  logic              req_ns,
  input  logic              sec_disable,
  output logic [NCORES-1:0] dlv_vec,
  output logic [3:0]        dlv_id,
  output logic [1:0]        dlv_grp,
  output logic              dlv_ns
);
  localparam int LIST_W  = 16;
  localparam int BCAST_B = 40;
  localparam logic [1:0] G0  = 2'd0;
  localparam logic [1:0] G1S = 2'd1;
  localparam logic [1:0] G1N = 2'd2;

  wire [23:0] req_upper = {req_data[55:48], req_data[39:32], req_data[23:16]};
  wire        bcast     = req_data[BCAST_B];
  wire [LIST_W-1:0] tlist = req_data[LIST_W-1:0];
  wire        port_ok   = (req_port != 2'd3);
  wire        accept    = req_valid && port_ok;
  wire        unused_bits = ^{req_data[63:56], req_data[47:41], req_data[31:28]};

  logic [NCORES-1:0] hit;

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    localparam logic [31:0] AFF = CORE_AFF[g*32 +: 32];
    localparam bit REACH = (AFF[7:0] < LIST_W);
    wire self = (req_core == CW'(g));
    wire tgt;
    if (REACH) begin : g_reach
      assign tgt = (AFF[31:8] == req_upper) && tlist[AFF[3:0]];
    end else begin : g_unreach
      assign tgt = 1'b0;
      p_far_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_data[BCAST_B]) |=> !dlv_vec[g]);
    end
    assign hit[g] = bcast ? !self : tgt;
  end

  logic [1:0] grp_raw, grp_res;
  always_comb begin
    case (req_port)
      2'd0:    grp_raw = G0;
      2'd1:    grp_raw = req_ns ? G1N : G1S;
      2'd2:    grp_raw = req_ns ? G1S : G1N;
      default: grp_raw = G0;
    endcase
    grp_res = (sec_disable && grp_raw == G1S) ? G0 : grp_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_vec <= '0;
      dlv_id  <= '0;
      dlv_grp <= G0;
      dlv_ns  <= 1'b0;
    end else begin
      dlv_vec <= accept ? hit : '0;
      if (accept) begin
        dlv_id  <= req_data[27:24];
        dlv_grp <= grp_res;
        dlv_ns  <= req_ns;
      end
    end
  end

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> dlv_vec == '0);
  p_port3_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_port == 2'd3) |=> dlv_vec == '0);
  p_noself_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_data[BCAST_B] && req_core < NCORES)
      |=> !dlv_vec[$past(req_core)] && $countones(dlv_vec) == NCORES - 1);
  p_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dlv_id == $past(req_data[27:24]));
  p_ns_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dlv_ns == $past(req_ns));
  p_g0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_port == 2'd0) |=> dlv_grp == G0);
  p_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sec_disable) |=> dlv_grp != G1S);
  p_grp_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_grp != 2'd3);
endmodule

// File: tb/test_sgi_router.sv
module test_sgi_router;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_ns = 1'b0, sec_disable = 1'b0;
  logic [63:0] req_data = '0;
  logic [1:0] req_port = '0;
  logic [2:0] req_core = '0;
  logic [N-1:0] dlv_vec;
  logic [3:0] dlv_id;
  logic [1:0] dlv_grp;
  logic dlv_ns;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] aff_tab [N] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_000F,
                               32'h0000_0100, 32'h0000_0105, 32'h0102_0100, 32'h0000_0114};

  sgi_router i_sgi_router (.clk, .rst_n, .req_valid, .req_data, .req_port, .req_core,
    .req_ns, .sec_disable, .dlv_vec, .dlv_id, .dlv_grp, .dlv_ns);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_vec(input logic [63:0] d, input logic [1:0] p, input int c);
    logic [N-1:0] v = '0;
    if (p == 2'd3) return '0;
    for (int i = 0; i < N; i++) begin
      if (d[40]) v[i] = (i != c);
      else v[i] = (aff_tab[i][31:8] == {d[55:48], d[39:32], d[23:16]}) &&
                  (aff_tab[i][7:0] <= 8'd15) && d[aff_tab[i][3:0]];
    end
    return v;
  endfunction

  function automatic logic [1:0] exp_grp(input logic [1:0] p, input logic ns, input logic sd);
    logic [1:0] g;
    case (p)
      2'd1: g = ns ? 2'd2 : 2'd1;
      2'd2: g = ns ? 2'd1 : 2'd2;
      default: g = 2'd0;
    endcase
    if (sd && g == 2'd1) g = 2'd0;
    return g;
  endfunction

  task automatic send(input logic [63:0] d, input logic [1:0] p, input int c,
                      input logic ns, input logic sd, input string tag);
    logic [N-1:0] ev = exp_vec(d, p, c);
    req_data = d; req_port = p; req_core = 3'(c); req_ns = ns; sec_disable = sd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_data = $urandom; req_port = 2'($urandom);
    check(dlv_vec == ev, {tag, " vec R3 R5 R12"}, 64'(dlv_vec), 64'(ev));
    if (p != 2'd3) begin
      check(dlv_id == d[27:24], "R2 id", 64'(dlv_id), 64'(d[27:24]));
      check(dlv_grp == exp_grp(p, ns, sd), {tag, " grp R6 R7 R8 R9"}, 64'(dlv_grp), 64'(exp_grp(p, ns, sd)));
      check(dlv_ns == ns, "R10 ns", 64'(dlv_ns), 64'(ns));
    end
    @(negedge clk);
    check(dlv_vec == '0, "R11 pulse width", 64'(dlv_vec), 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(dlv_vec == '0 && dlv_id == '0 && dlv_grp == '0 && !dlv_ns, "R1 reset", 64'(dlv_vec), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dlv_vec == '0 && dlv_grp == '0, "R1 after release", 64'(dlv_vec), 64'd0);

    send(64'h0000_0000_0500_800F, 2'd0, 4, 0, 0, "cluster0 full");
    send(64'h0001_0002_0A01_0001, 2'd1, 0, 1, 0, "aff3/aff2 cluster");
    send(64'h0000_0000_0301_FFFF, 2'd2, 0, 0, 0, "R4 level0 over 15");
    send(64'h0000_0000_0101_0000, 2'd1, 7, 0, 0, "R4 core7 never");
    send(64'hFF00_01FF_0F77_1234, 2'd1, 3, 1, 0, "R5 broadcast core3");
    send(64'h00FF_01FF_0077_FFFF, 2'd0, 0, 0, 1, "R5 broadcast core0");
    send(64'h0000_0000_0077_FFFF, 2'd0, 1, 0, 0, "R12 no match");
    send(64'hFF00_FE00_F000_FFFF, 2'd0, 1, 0, 0, "R12 ignored bits");
    send(64'h0000_0100_0000_FFFF, 2'd3, 1, 0, 0, "R12 port3");
    for (int p = 0; p < 3; p++)
      for (int ns = 0; ns < 2; ns++)
        for (int sd = 0; sd < 2; sd++)
          send(64'h0000_0000_0900_0003, 2'(p), 2, 1'(ns), 1'(sd), "R6 R7 R8 R9 table");

    for (int k = 0; k < 400; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      int sel = $urandom_range(0, 3);
      if (sel != 0) begin
        logic [31:0] a = aff_tab[$urandom_range(0, N - 1)];
        d[55:48] = a[31:24]; d[39:32] = a[23:16]; d[23:16] = a[15:8];
        if (sel != 3) d[40] = 1'b0;
      end
      send(d, 2'($urandom), $urandom_range(0, N - 1), 1'($urandom), 1'($urandom), "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule